// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the memory-mapped control and status face of a UART whose register layout is close to, but not compatible with, the classic 8250 layout. A host reaches ten 32-bit word registers through a simple select/write/address bus. The block stores the character format, the modem control lines, the baud divisor and the interrupt enables. It builds a line status word from FIFO occupancy and receiver error flags that arrive on input ports. It also produces push, pop and flush strobes for the external transmit and receive FIFOs, which each hold 128 entries.

One word holds both interrupt enables and interrupt status. The enables occupy bits [7:4] and are written by the host. The status occupies bits [3:0]. A status bit latches while its source condition holds and its enable is set, and it clears when the host reads the word. The interrupt output is a level signal. The serializer, the deserializer and the FIFO storage are outside this block.

Read data is registered and appears on `bus_rdata` one clock after the read cycle. Side effects of an access (pop, push, flush, status clear) act in the access cycle.

Top module: `uart_regfront`

## Requirements
- R1: After reset, every stored register reads 0, `irq` is 0, `bus_rdata` is 0 and all line and modem control outputs are 0.
- R2: The word index is address bits [5:2]: 0 data, 1 line status, 2 modem status, 3 line control, 4 modem control, 5 divisor low, 6 divisor high, 7 interrupt, 8 transmit residue, 9 receive residue. Line control keeps bits [5:0], modem control keeps bits [4:0], divisor low keeps bits [15:0] and divisor high keeps bits [7:0]. Each reads back exactly those bits, with zeros above them.
- R3: Line control drives the outputs as follows: `word_len` from bits [1:0], `two_stop` from bit2, `par_en` from bit3, `par_even` from bit4, and `tx_break` from bit5. Modem control drives `dtr`, `rts`, `dcd`, `ri` and `loopback` from bits 0 through 4.
- R4: A write to the data word while `tx_full` is 0 raises `tx_push` in that cycle, with `tx_byte` equal to write data bits [7:0]. While `tx_full` is 1, `tx_push` stays 0 and the byte is dropped.
- R5: A read of the data word while `rx_empty` is 0 raises `rx_pop` in that cycle and returns `rx_byte`. While `rx_empty` is 1, the read returns 0 and `rx_pop` stays 0.
- R6: The line status word has these bits: bit0 is not `tx_full`, bit1 is not `rx_empty`, bit2 is `rx_par_err`, bit3 is `rx_ovr_err`, bit4 is `rx_frm_err`, bit5 is `rx_brk`, and bit6 is `tx_empty` AND `tx_idle`. All other bits are 0.
- R7: A write to the interrupt word stores only bits [7:4]. Bit5 enables the receive source and bit4 enables the transmit source. Writing 0 disables both sources.
- R8: Status bit1 sets while `rx_empty` is 0 and bit5 is 1. Status bit0 sets while `tx_full` is 0 and bit4 is 1. A status bit stays set until the interrupt word is read. That read returns the pre-clear value and leaves the status at 0 after the cycle.
- R9: `irq` is 1 exactly when (status bit1 AND bit5) OR (status bit0 AND bit4).
- R10: Any write to the receive residue word raises `rx_flush` for that cycle. Writes to other words do not.
- R11: The modem status word returns `modem_status` in bits [3:0].
- R12: Reads of the transmit residue word and of indexes 10 to 15 return 0. Writes to those indexes change no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 6 | Byte address; bits [5:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| tx_full | input | 1 | Transmit FIFO full |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_idle | input | 1 | Transmit shifter idle |
| tx_push | output | 1 | Push strobe to transmit FIFO |
| tx_byte | output | 8 | Byte to push |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_byte | input | 8 | Byte at head of receive FIFO |
| rx_par_err | input | 1 | Parity error flag |
| rx_ovr_err | input | 1 | Overrun flag |
| rx_frm_err | input | 1 | Framing error flag |
| rx_brk | input | 1 | Break detected flag |
| rx_pop | output | 1 | Pop strobe to receive FIFO |
| rx_flush | output | 1 | Flush strobe to receive FIFO |
| modem_status | input | 4 | Modem status inputs |
| word_len | output | 2 | Character length code, 0 for 5 bits up to 3 for 8 bits |
| two_stop | output | 1 | Two stop bits |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity |
| tx_break | output | 1 | Force break on transmit line |
| dtr | output | 1 | Data terminal ready |
| rts | output | 1 | Request to send |
| dcd | output | 1 | Carrier detect control |
| ri | output | 1 | Ring indicator control |
| loopback | output | 1 | Loopback mode |
| div_lo | output | 16 | Divisor low word |
| div_hi | output | 8 | Divisor high byte |
| irq | output | 1 | Level interrupt |

## Verification
A corrupted enable or status bit shows on `irq` in the cycle after the fault. It also shows on the interrupt word one clock after any read of that word. A decode fault shows in the same cycle as a wrong strobe on `tx_push`, `rx_pop` or `rx_flush`. It also shows as a readback mismatch one clock after the next read. The bench reads twice back-to-back to expose a status bit that fails to clear, or one that sets again in the same cycle it is cleared. It also checks that enables survive a write of ones to the status half.

// File: rtl/uart_regfront_pkg.sv
// Shared word indexes and bit positions for the UART register front end.
package uart_regfront_pkg;
    localparam int NUM_REGS = 10;

    typedef enum logic [3:0] {
        RG_DATA  = 4'd0,
        RG_LSR   = 4'd1,
        RG_MSR   = 4'd2,
        RG_LCR   = 4'd3,
        RG_MCR   = 4'd4,
        RG_DIVL  = 4'd5,
        RG_DIVH  = 4'd6,
        RG_ISC   = 4'd7,
        RG_TXRES = 4'd8,
        RG_RXRES = 4'd9
    } reg_idx_e;

    // interrupt source slots inside the enable and status nibbles
    localparam int SRC_TX = 0;
    localparam int SRC_RX = 1;
    localparam int NUM_SRC = 2;
endpackage

// File: rtl/uart_regfront_decode.sv
// Address decoder: turns one bus access into one-hot read and write hits.
// Assumes word-aligned addresses; the two low address bits are ignored.
module uart_regfront_decode #(
    parameter int ADDR_W   = 6,
    parameter int NUM_REGS = 10
) (
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic [NUM_REGS-1:0] wr_hit,
    output logic [NUM_REGS-1:0] rd_hit
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    assign idx = bus_addr[ADDR_W-1:2];

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_hit
            // one comparator per mapped word
            assign wr_hit[g] = bus_sel &  bus_wr & (idx == IDX_W'(g));
            assign rd_hit[g] = bus_sel & ~bus_wr & (idx == IDX_W'(g));
        end
    endgenerate
endmodule

// File: rtl/uart_regfront_cfg.sv
// Configuration storage: line control, modem control and divisor words.
// Assumes write strobes are one-hot; each register keeps only its own width.
module uart_regfront_cfg #(
    parameter int LCR_W  = 6,
    parameter int MCR_W  = 5,
    parameter int DIVL_W = 16,
    parameter int DIVH_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lcr,
    input  logic              wr_mcr,
    input  logic              wr_divl,
    input  logic              wr_divh,
    input  logic [DIVL_W-1:0] wdata,
    output logic [LCR_W-1:0]  lcr_q,
    output logic [MCR_W-1:0]  mcr_q,
    output logic [DIVL_W-1:0] divl_q,
    output logic [DIVH_W-1:0] divh_q
);
    // line control register
    always_ff @(posedge clk) begin
        if (!rst_n)      lcr_q <= '0;
        else if (wr_lcr) lcr_q <= wdata[LCR_W-1:0];
    end

    // modem control register
    always_ff @(posedge clk) begin
        if (!rst_n)      mcr_q <= '0;
        else if (wr_mcr) mcr_q <= wdata[MCR_W-1:0];
    end

    // divisor low word, including the fractional nibble
    always_ff @(posedge clk) begin
        if (!rst_n)       divl_q <= '0;
        else if (wr_divl) divl_q <= wdata;
    end

    // divisor high byte
    always_ff @(posedge clk) begin
        if (!rst_n)       divh_q <= '0;
        else if (wr_divh) divh_q <= wdata[DIVH_W-1:0];
    end
endmodule

// File: rtl/uart_regfront_irq.sv
// Interrupt word: host-written enables in the upper nibble and sticky
// status in the lower nibble that clears on read.
// Assumes a read and a write of this word never occur in the same cycle.
module uart_regfront_irq
    import uart_regfront_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_isc,
    input  logic             rd_isc,
    input  logic [NIB_W-1:0] wr_en,
    input  logic             rx_avail,
    input  logic             tx_space,
    output logic [NIB_W-1:0] en_q,
    output logic [NIB_W-1:0] st_q,
    output logic             irq
);
    logic [NUM_SRC-1:0] cond;
    logic [NUM_SRC-1:0] fire;

    assign cond[SRC_TX] = tx_space;
    assign cond[SRC_RX] = rx_avail;

    // enable nibble: only a write to this word changes it
    always_ff @(posedge clk) begin
        if (!rst_n)      en_q <= '0;
        else if (wr_isc) en_q <= wr_en;
    end

    genvar s;
    generate
        for (s = 0; s < NUM_SRC; s++) begin : g_src
            // sticky status: a read clears it and wins over a new set
            always_ff @(posedge clk) begin
                if (!rst_n)                st_q[s] <= 1'b0;
                else if (rd_isc)           st_q[s] <= 1'b0;
                else if (cond[s] & en_q[s]) st_q[s] <= 1'b1;
            end
            assign fire[s] = st_q[s] & en_q[s];
        end
        for (s = NUM_SRC; s < NIB_W; s++) begin : g_spare
            assign st_q[s] = 1'b0;
        end
    endgenerate

    assign irq = |fire;
endmodule

// File: rtl/uart_regfront.sv
// UART register front end top: decodes word accesses, muxes read data into a
// register, drives FIFO strobes and exposes line, modem and divisor settings.
// Assumes external FIFOs accept push or pop in the cycle the strobe is high.
module uart_regfront
    import uart_regfront_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int CHAR_W = 8,
    parameter int DIVL_W = 16,
    parameter int DIVH_W = 8,
    parameter int MSR_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tx_full,
    input  logic              tx_empty,
    input  logic              tx_idle,
    output logic              tx_push,
    output logic [CHAR_W-1:0] tx_byte,
    input  logic              rx_empty,
    input  logic [CHAR_W-1:0] rx_byte,
    input  logic              rx_par_err,
    input  logic              rx_ovr_err,
    input  logic              rx_frm_err,
    input  logic              rx_brk,
    output logic              rx_pop,
    output logic              rx_flush,
    input  logic [MSR_W-1:0]  modem_status,
    output logic [1:0]        word_len,
    output logic              two_stop,
    output logic              par_en,
    output logic              par_even,
    output logic              tx_break,
    output logic              dtr,
    output logic              rts,
    output logic              dcd,
    output logic              ri,
    output logic              loopback,
    output logic [DIVL_W-1:0] div_lo,
    output logic [DIVH_W-1:0] div_hi,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - 2;
    localparam int LCR_W = 6;
    localparam int MCR_W = 5;
    localparam int NIB_W = 4;
    localparam int LSR_W = 7;

    logic [NUM_REGS-1:0] wr_hit;
    logic [NUM_REGS-1:0] rd_hit;
    logic [LCR_W-1:0]    lcr_q;
    logic [MCR_W-1:0]    mcr_q;
    logic [NIB_W-1:0]    isc_en;
    logic [NIB_W-1:0]    isc_st;
    logic [LSR_W-1:0]    lsr;
    logic [DATA_W-1:0]   rd_mux;
    logic [DATA_W-1:0]   rdata_q;
    logic [IDX_W-1:0]    idx;
    logic                unused_bits;

    assign idx = bus_addr[ADDR_W-1:2];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:DIVL_W]};

    uart_regfront_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .wr_hit   (wr_hit),
        .rd_hit   (rd_hit)
    );

    uart_regfront_cfg #(
        .LCR_W  (LCR_W),
        .MCR_W  (MCR_W),
        .DIVL_W (DIVL_W),
        .DIVH_W (DIVH_W)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_lcr  (wr_hit[RG_LCR]),
        .wr_mcr  (wr_hit[RG_MCR]),
        .wr_divl (wr_hit[RG_DIVL]),
        .wr_divh (wr_hit[RG_DIVH]),
        .wdata   (bus_wdata[DIVL_W-1:0]),
        .lcr_q   (lcr_q),
        .mcr_q   (mcr_q),
        .divl_q  (div_lo),
        .divh_q  (div_hi)
    );

    uart_regfront_irq #(
        .NIB_W (NIB_W)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_isc   (wr_hit[RG_ISC]),
        .rd_isc   (rd_hit[RG_ISC]),
        .wr_en    (bus_wdata[2*NIB_W-1:NIB_W]),
        .rx_avail (~rx_empty),
        .tx_space (~tx_full),
        .en_q     (isc_en),
        .st_q     (isc_st),
        .irq      (irq)
    );

    // FIFO strobes, gated by occupancy so the FIFOs never over- or underflow
    assign tx_push  = wr_hit[RG_DATA] & ~tx_full;
    assign tx_byte  = bus_wdata[CHAR_W-1:0];
    assign rx_pop   = rd_hit[RG_DATA] & ~rx_empty;
    assign rx_flush = wr_hit[RG_RXRES];

    // line control and modem control fields to the serial engine
    assign word_len = lcr_q[1:0];
    assign two_stop = lcr_q[2];
    assign par_en   = lcr_q[3];
    assign par_even = lcr_q[4];
    assign tx_break = lcr_q[5];
    assign dtr      = mcr_q[0];
    assign rts      = mcr_q[1];
    assign dcd      = mcr_q[2];
    assign ri       = mcr_q[3];
    assign loopback = mcr_q[4];

    // line status assembled from FIFO and receiver flags
    assign lsr = {tx_empty & tx_idle, rx_brk, rx_frm_err, rx_ovr_err,
                  rx_par_err, ~rx_empty, ~tx_full};

    // read data selection by word index
    always_comb begin
        rd_mux = '0;
        case (idx)
            IDX_W'(RG_DATA): rd_mux = rx_empty ? '0 : DATA_W'(rx_byte);
            IDX_W'(RG_LSR):  rd_mux = DATA_W'(lsr);
            IDX_W'(RG_MSR):  rd_mux = DATA_W'(modem_status);
            IDX_W'(RG_LCR):  rd_mux = DATA_W'(lcr_q);
            IDX_W'(RG_MCR):  rd_mux = DATA_W'(mcr_q);
            IDX_W'(RG_DIVL): rd_mux = DATA_W'(div_lo);
            IDX_W'(RG_DIVH): rd_mux = DATA_W'(div_hi);
            IDX_W'(RG_ISC):  rd_mux = DATA_W'({isc_en, isc_st});
            default:         rd_mux = '0;
        endcase
    end

    // read data register, loaded on every read access
    always_ff @(posedge clk) begin
        if (!rst_n)                 rdata_q <= '0;
        else if (bus_sel & ~bus_wr) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/uart_regfront_chk.sv
// Property checker for the UART register front end, bound to the top.
module uart_regfront_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int CHAR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tx_full,
    input logic              tx_push,
    input logic              rx_empty,
    input logic [CHAR_W-1:0] rx_byte,
    input logic              rx_pop,
    input logic              rx_flush,
    input logic [3:0]        isc_en,
    input logic [3:0]        isc_st,
    input logic              irq
);
    logic isc_wr;
    logic isc_rd;
    assign isc_wr = bus_sel &  bus_wr & (bus_addr[ADDR_W-1:2] == 4'd7);
    assign isc_rd = bus_sel & ~bus_wr & (bus_addr[ADDR_W-1:2] == 4'd7);

    p_push_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> !tx_full);

    p_pop_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> !rx_empty);

    p_pop_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |=> bus_rdata == DATA_W'($past(rx_byte)));

    p_enable_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        isc_wr |=> isc_en == $past(bus_wdata[7:4]));

    p_status_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        isc_rd |=> isc_st == 4'd0);

    p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (isc_en[1:0] != 2'b00));

    p_flush_not_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |-> !rx_pop);
endmodule

bind uart_regfront uart_regfront_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CHAR_W (CHAR_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_full   (tx_full),
    .tx_push   (tx_push),
    .rx_empty  (rx_empty),
    .rx_byte   (rx_byte),
    .rx_pop    (rx_pop),
    .rx_flush  (rx_flush),
    .isc_en    (isc_en),
    .isc_st    (isc_st),
    .irq       (irq)
);

// File: tb/uart_regfront_tb.sv
`timescale 1ns/1ps
// Self-checking bench: a readback vector table, then directed tests.
module uart_regfront_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_full = 1'b1;
    logic        tx_empty = 1'b0;
    logic        tx_idle = 1'b0;
    logic        tx_push;
    logic [7:0]  tx_byte;
    logic        rx_empty = 1'b1;
    logic [7:0]  rx_byte = '0;
    logic        rx_par_err = 1'b0;
    logic        rx_ovr_err = 1'b0;
    logic        rx_frm_err = 1'b0;
    logic        rx_brk = 1'b0;
    logic        rx_pop;
    logic        rx_flush;
    logic [3:0]  modem_status = '0;
    logic [1:0]  word_len;
    logic        two_stop, par_en, par_even, tx_break;
    logic        dtr, rts, dcd, ri, loopback;
    logic [15:0] div_lo;
    logic [7:0]  div_hi;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_regfront dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_idle(tx_idle),
        .tx_push(tx_push), .tx_byte(tx_byte), .rx_empty(rx_empty),
        .rx_byte(rx_byte), .rx_par_err(rx_par_err), .rx_ovr_err(rx_ovr_err),
        .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .rx_pop(rx_pop),
        .rx_flush(rx_flush), .modem_status(modem_status),
        .word_len(word_len), .two_stop(two_stop), .par_en(par_en),
        .par_even(par_even), .tx_break(tx_break), .dtr(dtr), .rts(rts),
        .dcd(dcd), .ri(ri), .loopback(loopback), .div_lo(div_lo),
        .div_hi(div_hi), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic [31:0] val;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 6'h0C, 32'h0000_003F}, '{1'b0, 6'h0C, 32'h0000_003F},
        '{1'b1, 6'h0C, 32'hFFFF_FFC5}, '{1'b0, 6'h0C, 32'h0000_0005},
        '{1'b1, 6'h10, 32'h0000_00FF}, '{1'b0, 6'h10, 32'h0000_001F},
        '{1'b1, 6'h14, 32'h0000_F0AB}, '{1'b0, 6'h14, 32'h0000_F0AB},
        '{1'b1, 6'h14, 32'h1234_5678}, '{1'b0, 6'h14, 32'h0000_5678},
        '{1'b1, 6'h18, 32'h0000_01FF}, '{1'b0, 6'h18, 32'h0000_00FF}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; drive, let the rising edge pass, release
    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin : watchdog
        #(20 * 100000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        chk("R1 rdata", bus_rdata, 32'd0);
        chk("R1 ctrl outs", {23'd0, word_len, two_stop, par_en, par_even, tx_break,
            dtr, rts, dcd, ri, loopback}, 32'd0);
        bus_read(6'h1C, rd); chk("R1 isc", rd, 32'd0);
        bus_read(6'h0C, rd); chk("R1 lcr", rd, 32'd0);

        // R2 readback table
        for (int i = 0; i < NVEC; i++) begin
            if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].val);
            else begin
                bus_read(VECS[i].addr, rd);
                chk("R2 readback", rd, VECS[i].val);
            end
        end
        chk("R2 div_lo port", {16'd0, div_lo}, 32'h5678);
        chk("R2 div_hi port", {24'd0, div_hi}, 32'hFF);

        // R3 field outputs
        bus_write(6'h0C, 32'h2D);
        chk("R3 lcr fields", {27'd0, word_len, two_stop, par_en, par_even, tx_break} , 32'b01_1_1_0_1);
        bus_write(6'h10, 32'h0A);
        chk("R3 mcr fields", {27'd0, dtr, rts, dcd, ri, loopback}, 32'b0_1_0_1_0);

        // R4 transmit push
        tx_full = 1'b0;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h00; bus_wdata = 32'hFFFF_FFA5;
        #2;
        chk("R4 push", {23'd0, tx_push, tx_byte}, {23'd0, 1'b1, 8'hA5});
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
        tx_full = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h00; bus_wdata = 32'h5A;
        #2;
        chk("R4 full drop", {31'd0, tx_push}, 32'd0);
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;

        // R5 receive pop
        rx_empty = 1'b0; rx_byte = 8'h3C;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'h00;
        #2;
        chk("R5 pop", {31'd0, rx_pop}, 32'd1);
        @(negedge clk); bus_sel = 1'b0;
        chk("R5 data", bus_rdata, 32'h3C);
        rx_empty = 1'b1;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'h00;
        #2;
        chk("R5 empty no pop", {31'd0, rx_pop}, 32'd0);
        @(negedge clk); bus_sel = 1'b0;
        chk("R5 empty data", bus_rdata, 32'd0);

        // R6 line status patterns
        tx_full = 1'b0; rx_empty = 1'b0; rx_par_err = 1'b1; rx_frm_err = 1'b1;
        tx_empty = 1'b1; tx_idle = 1'b1;
        bus_read(6'h04, rd); chk("R6 lsr a", rd, 32'h57);
        tx_full = 1'b1; rx_empty = 1'b1; rx_par_err = 1'b0; rx_frm_err = 1'b0;
        rx_ovr_err = 1'b1; rx_brk = 1'b1; tx_idle = 1'b0;
        bus_read(6'h04, rd); chk("R6 lsr b", rd, 32'h28);
        rx_ovr_err = 1'b0; rx_brk = 1'b0;

        // R7 enable write keeps status untouched
        bus_write(6'h1C, 32'hFF);
        bus_read(6'h1C, rd); chk("R7 isc enables only", rd, 32'hF0);
        chk("R9 no irq without status", {31'd0, irq}, 32'd0);

        // R8 and R9 receive source
        rx_empty = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R9 irq rx", {31'd0, irq}, 32'd1);
        bus_read(6'h1C, rd); chk("R8 rx status", rd, 32'hF2);
        bus_read(6'h1C, rd); chk("R8 cleared on read", rd, 32'hF0);
        @(negedge clk);
        chk("R8 resets while pending", {31'd0, irq}, 32'd1);
        rx_empty = 1'b1;
        bus_read(6'h1C, rd); chk("R8 sticky", rd, 32'hF2);
        bus_read(6'h1C, rd); chk("R8 clear after source gone", rd, 32'hF0);
        chk("R9 irq low", {31'd0, irq}, 32'd0);

        // R8 transmit source, then R7 disable with zero
        tx_full = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R9 irq tx", {31'd0, irq}, 32'd1);
        bus_write(6'h1C, 32'h00);
        chk("R7 zero disables irq", {31'd0, irq}, 32'd0);
        bus_read(6'h1C, rd);
        tx_full = 1'b1;
        bus_write(6'h1C, 32'h0F);
        @(negedge clk);
        bus_read(6'h1C, rd); chk("R7 low nibble ignored", rd, 32'h00);

        // R10 flush
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h24; bus_wdata = 32'h0;
        #2;
        chk("R10 flush", {31'd0, rx_flush}, 32'd1);
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h10; bus_wdata = 32'h0;
        #2;
        chk("R10 no flush elsewhere", {31'd0, rx_flush}, 32'd0);
        @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;

        // R11 modem status
        modem_status = 4'hA;
        bus_read(6'h08, rd); chk("R11 msr", rd, 32'h0A);

        // R12 unmapped and residue words
        bus_write(6'h28, 32'hFFFF_FFFF);
        bus_write(6'h3C, 32'hFFFF_FFFF);
        bus_read(6'h28, rd); chk("R12 unmapped read", rd, 32'd0);
        bus_read(6'h20, rd); chk("R12 tx residue", rd, 32'd0);
        bus_read(6'h0C, rd); chk("R12 lcr unchanged", rd, 32'h2D);
        bus_read(6'h1C, rd); chk("R12 isc unchanged", rd, 32'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule